// File: doc/BRIEF.md
# Fixed-Length SPI Register Frame Decoder

This block is the serial front end of a small control chip. A host talks to it in 16-bit frames, most significant bit first, with chip select held low for the whole frame. The top two bits of a frame pick a register. Two control bits follow. One chooses which of two registers the block sends back on MISO. The other chooses between a plain read and a read combined with a write. The block counts the serial clocks inside each frame. When chip select is released it acts on that count: a frame of exactly sixteen clocks may update the interrupt-enable register, and any other length counts as a length fault.

The serial pins are sampled by the block's own system clock through synchronisers, so SCLK has to be several times slower than `clk`. Frames are accepted one per chip-select window, with no buffering and no back-pressure. The host owns the pace, so there is no valid/ready handshake: each frame is either committed or discarded when it ends. The operating mode is an input. It decides whether a length fault raises an interrupt or asks for a reset.

Top module: `spi_reg_frame_decoder`

## Requirements
- R1: After reset `ien_reg` is 0, `miso` is 0, and `ien_we`, `irq_spi_fail` and `rst_req` are low.
- R2: A frame with exactly 16 SCLK rising edges, address field (bits 15:14) = 2'b01 and read-only bit (bit 12) = 0 writes frame bits 11:4 into `ien_reg` (frame bit 11 goes to `ien_reg[7]`). It gives one `ien_we` pulse, and both happen only after chip select is released.
- R3: When bit 12 = 1, `ien_reg` keeps its value and `ien_we` stays low.
- R4: MISO changes on SCLK falling edges and is meant to be sampled on rising edges. Frame bits 15:12 and 3:0 read 0. Bits 11:4 carry `irq_status` when bit 13 = 1, or `ien_reg` as it stood before this frame when bit 13 = 0.
- R5: `ien_reg[0]` (frame bit 4) is reserved: it always reads 0, whatever value is written to it.
- R6: A frame whose SCLK count is not 16 (0 to 15, or more than 16) never writes `ien_reg`. When `ien_reg[4]` (frame bit 8, length-fault enable) is 0, the frame also raises neither `irq_spi_fail` nor `rst_req`.
- R7: A length fault with `ien_reg[4]` = 1 and `op_mode` normal (2'b00, or 2'b11) gives one `irq_spi_fail` pulse and no `rst_req`.
- R8: A length fault with `ien_reg[4]` = 1 and `op_mode` start-up (2'b01) or restart (2'b10) gives one `rst_req` pulse and no `irq_spi_fail`.
- R9: A frame whose address field is not 2'b01 never writes `ien_reg`, and all 16 MISO bits read 0.
- R10: If the last SCLK rising edge and the chip-select release arrive in the same sample, that edge still counts toward the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all SPI pins are oversampled by it |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI serial clock, idle low |
| cs_n | input | 1 | Active-low chip select; its release ends the frame |
| mosi | input | 1 | Serial data from the host, MSB first |
| miso | output | 1 | Serial data to the host |
| op_mode | input | 2 | 00 normal, 01 start-up, 10 restart, 11 normal |
| irq_status | input | 8 | Interrupt status contents, returned when bit 13 = 1 |
| ien_reg | output | 8 | Interrupt-enable register (frame bits 11:4) |
| ien_we | output | 1 | One-cycle strobe when `ien_reg` is written |
| irq_spi_fail | output | 1 | One-cycle pulse: length fault reported as interrupt |
| rst_req | output | 1 | One-cycle pulse: length fault reported as reset request |

## Verification
Two events can land in the same sample cycle: the sixteenth SCLK rising edge, which moves the bit counter, and the chip-select release, which starts the length check. The bench provokes this by raising SCLK and chip select at the same instant on the last bit. In that case the frame must still be judged as 16 clocks and committed. The same trick applied to a 17-clock frame must still be rejected. The result is judged only from `ien_reg`, `ien_we` and the fault pulses.

// File: rtl/spi_frm_pkg.sv
package spi_frm_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'b00,
    MODE_STARTUP = 2'b01,
    MODE_RESTART = 2'b10,
    MODE_SPARE   = 2'b11
  } op_mode_e;

  localparam logic [1:0] ADDR_IEN  = 2'b01;
  localparam int         HDR_W     = 4;   // address(2) + read select + read only
  localparam int         SPIF_BIT  = 8;   // frame bit holding the length-fault enable
endpackage

// File: rtl/spi_frm_sync.sv
module spi_frm_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= RST_VAL;
        else if (g == 0) chain[g] <= din;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/spi_frm_shifter.sv
module spi_frm_shifter
  import spi_frm_pkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int REG_W   = 8,
  parameter int CNT_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_fall,
  input  logic               cs_act,
  input  logic               cs_rise,
  input  logic               sclk_rise,
  input  logic               sclk_fall,
  input  logic               mosi_s,
  input  logic [REG_W-1:0]   sel_data,
  output logic [FRAME_W-1:0] shreg,
  output logic [CNT_W-1:0]   cnt,
  output logic               miso
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam int IDX_W = (REG_W > 1) ? $clog2(REG_W) : 1;

  logic             take;
  logic [REG_W-1:0] snap, snap_nxt;
  logic             in_data;
  logic [IDX_W-1:0] idx;
  int               idx_i;

  // An edge arriving with the release still belongs to the frame.
  assign take = sclk_rise & (cs_act | cs_rise);

  always_comb begin
    snap_nxt = (int'(cnt) == HDR_W) ? sel_data : snap;
    in_data  = (int'(cnt) >= HDR_W) && (int'(cnt) < HDR_W + REG_W);
    idx_i    = HDR_W + REG_W - 1 - int'(cnt);
    idx      = in_data ? IDX_W'(idx_i) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (cs_fall) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (take) begin
      shreg <= {shreg[FRAME_W-2:0], mosi_s};
      if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap <= '0;
      miso <= 1'b0;
    end else if (cs_fall || cs_rise) begin
      snap <= '0;
      miso <= 1'b0;
    end else if (sclk_fall && cs_act) begin
      snap <= snap_nxt;
      miso <= in_data ? snap_nxt[idx] : 1'b0;
    end
  end

  AST_HDR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && int'(cnt) < HDR_W) |-> !miso); // R4
endmodule

// File: rtl/spi_frm_commit.sv
module spi_frm_commit
  import spi_frm_pkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int REG_W   = 8,
  parameter int CNT_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit,
  input  logic [CNT_W-1:0]   cnt,
  input  logic [FRAME_W-1:0] shreg,
  input  logic [1:0]         op_mode,
  output logic [REG_W-1:0]   ien_reg,
  output logic               ien_we,
  output logic               irq_spi_fail,
  output logic               rst_req
);
  localparam int DATA_LSB = FRAME_W - HDR_W - REG_W;
  localparam int SPIF_IDX = SPIF_BIT - DATA_LSB;
  localparam logic [REG_W-1:0] KEEP_MASK = ~(REG_W'(1));

  logic             frame_ok, ro, spif_en, reset_mode;
  logic [1:0]       addr;
  logic [REG_W-1:0] wdata;

  always_comb begin
    frame_ok   = (int'(cnt) == FRAME_W);
    addr       = shreg[FRAME_W-1 -: 2];
    ro         = shreg[FRAME_W-4];
    wdata      = shreg[FRAME_W-HDR_W-1 -: REG_W];
    spif_en    = ien_reg[SPIF_IDX];
    reset_mode = (op_mode == MODE_STARTUP) || (op_mode == MODE_RESTART);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_reg      <= '0;
      ien_we       <= 1'b0;
      irq_spi_fail <= 1'b0;
      rst_req      <= 1'b0;
    end else begin
      ien_we       <= 1'b0;
      irq_spi_fail <= 1'b0;
      rst_req      <= 1'b0;
      if (commit) begin
        if (frame_ok) begin
          if (addr == ADDR_IEN && !ro) begin
            ien_reg <= wdata & KEEP_MASK;
            ien_we  <= 1'b1;
          end
        end else if (spif_en) begin
          if (reset_mode) rst_req <= 1'b1;
          else irq_spi_fail <= 1'b1;
        end
      end
    end
  end

  AST_WE_FULL_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    ien_we |-> (int'($past(cnt)) == FRAME_W)); // R2
  AST_IEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ien_we |-> $stable(ien_reg)); // R3
  AST_FAULT_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_spi_fail || rst_req) |-> (int'($past(cnt)) != FRAME_W)); // R6
  AST_ONE_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_spi_fail && rst_req)); // R8
endmodule

// File: rtl/spi_reg_frame_decoder.sv
module spi_reg_frame_decoder
  import spi_frm_pkg::*;
#(
  parameter int FRAME_W     = 16,
  parameter int REG_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk,
  input  logic             cs_n,
  input  logic             mosi,
  output logic             miso,
  input  logic [1:0]       op_mode,
  input  logic [REG_W-1:0] irq_status,
  output logic [REG_W-1:0] ien_reg,
  output logic             ien_we,
  output logic             irq_spi_fail,
  output logic             rst_req
);
  localparam int CNT_W = $clog2(FRAME_W) + 2;

  logic sclk_s, cs_n_s, mosi_s;
  logic sclk_q, cs_n_q, commit_q;
  logic sclk_rise, sclk_fall, cs_rise, cs_fall, cs_act;
  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   cnt;
  logic [REG_W-1:0]   sel_data;

  spi_frm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
    .clk(clk), .rst_n(rst_n), .din(sclk), .dout(sclk_s));
  spi_frm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
    .clk(clk), .rst_n(rst_n), .din(cs_n), .dout(cs_n_s));
  spi_frm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mosi (
    .clk(clk), .rst_n(rst_n), .din(mosi), .dout(mosi_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q   <= 1'b0;
      cs_n_q   <= 1'b1;
      commit_q <= 1'b0;
    end else begin
      sclk_q   <= sclk_s;
      cs_n_q   <= cs_n_s;
      commit_q <= cs_rise;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_q;
  assign sclk_fall = ~sclk_s & sclk_q;
  assign cs_rise   = cs_n_s & ~cs_n_q;
  assign cs_fall   = ~cs_n_s & cs_n_q;
  assign cs_act    = ~cs_n_s;

  // Header is complete after HDR_W bits: shreg[3:2] address, shreg[1] read select.
  always_comb begin
    if (shreg[HDR_W-1 -: 2] == ADDR_IEN)
      sel_data = shreg[HDR_W-3] ? irq_status : ien_reg;
    else
      sel_data = '0;
  end

  spi_frm_shifter #(.FRAME_W(FRAME_W), .REG_W(REG_W), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_act(cs_act),
    .cs_rise(cs_rise), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .mosi_s(mosi_s), .sel_data(sel_data), .shreg(shreg), .cnt(cnt),
    .miso(miso));

  spi_frm_commit #(.FRAME_W(FRAME_W), .REG_W(REG_W), .CNT_W(CNT_W)) u_commit (
    .clk(clk), .rst_n(rst_n), .commit(commit_q), .cnt(cnt), .shreg(shreg),
    .op_mode(op_mode), .ien_reg(ien_reg), .ien_we(ien_we),
    .irq_spi_fail(irq_spi_fail), .rst_req(rst_req));

  AST_WE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ien_we |-> $past(cs_rise, 2)); // R2
  AST_RESERVED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ien_we |-> !ien_reg[0]); // R5
endmodule

// File: tb/spi_reg_frame_decoder_tb.sv
module spi_reg_frame_decoder_tb_top;
  localparam int HNS = 160;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  logic [1:0] op_mode = 2'b00;
  logic [7:0] irq_status = 8'h00;
  logic [7:0] ien_reg;
  logic ien_we, irq_spi_fail, rst_req;

  int checks = 0, failures = 0;
  int we_cnt = 0, irq_cnt = 0, rst_cnt = 0;
  bit done = 1'b0;
  logic [7:0] model = 8'h00;

  always #10 clk = ~clk;

  spi_reg_frame_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .op_mode(op_mode), .irq_status(irq_status),
    .ien_reg(ien_reg), .ien_we(ien_we), .irq_spi_fail(irq_spi_fail),
    .rst_req(rst_req));

  always @(posedge clk) begin
    if (ien_we) we_cnt <= we_cnt + 1;
    if (irq_spi_fail) irq_cnt <= irq_cnt + 1;
    if (rst_req) rst_cnt <= rst_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic frame(input logic [15:0] w, input int n, input bit merge,
                       output logic [15:0] rd);
    rd = '0;
    cs_n = 1'b0;
    #HNS;
    for (int i = 0; i < n; i++) begin
      mosi = (i < 16) ? w[15-i] : 1'b0;
      #HNS;
      if (i < 16) rd[15-i] = miso;
      if (merge && i == n-1) begin
        sclk = 1'b1; cs_n = 1'b1;
        #HNS;
        sclk = 1'b0;
      end else begin
        sclk = 1'b1;
        #HNS;
        sclk = 1'b0;
      end
    end
    #HNS;
    cs_n = 1'b1;
    mosi = 1'b0;
    #(HNS*3);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd, exp_rd;
    int w0, i0, r0;
    #93;
    rst_n = 1'b1;
    #200;
    // R1 reset state
    chk(ien_reg == 8'h00, "R1", "ien_reg after reset", ien_reg, 0);
    chk(miso == 1'b0, "R1", "miso after reset", miso, 0);
    chk(!ien_we && !irq_spi_fail && !rst_req, "R1", "pulses after reset",
        {ien_we, irq_spi_fail, rst_req}, 0);

    // R2 R3 R4 R5 sweep over data, read select and read only
    for (int i = 0; i < 24; i++) begin
      logic [7:0] d;
      logic rsel, ro;
      d = 8'(i * 37 + 8'h5B);
      rsel = i[0];
      ro = i[1] & i[2];
      irq_status = 8'(~(i * 19));
      exp_rd = {4'b0000, (rsel ? irq_status : model), 4'b0000};
      w0 = we_cnt;
      frame({2'b01, rsel, ro, d, 4'hA}, 16, 1'b0, rd);
      chk(rd == exp_rd, "R4", "miso readback", rd, exp_rd);
      if (!ro) model = d & 8'hFE;
      chk(ien_reg == model, ro ? "R3" : "R2", "ien_reg after frame", ien_reg, model);
      chk(we_cnt - w0 == (ro ? 0 : 1), ro ? "R3" : "R2", "write strobes",
          we_cnt - w0, ro ? 0 : 1);
      chk(ien_reg[0] == 1'b0, "R5", "reserved bit", ien_reg[0], 0);
    end

    // R9 other addresses
    for (int a = 0; a < 4; a++) begin
      if (a == 1) continue;
      w0 = we_cnt;
      frame({2'(a), 2'b10, 8'hFF, 4'hF}, 16, 1'b0, rd);
      chk(rd == 16'h0000, "R9", "miso for foreign address", rd, 0);
      chk(ien_reg == model && we_cnt == w0, "R9", "ien_reg foreign address",
          ien_reg, model);
    end

    // R6 R7 R8 length faults across enable, mode and count
    for (int en = 0; en < 2; en++) begin
      frame({2'b01, 2'b00, (en != 0) ? 8'h11 : 8'h20, 4'h0}, 16, 1'b0, rd);
      model = (en != 0) ? 8'h10 : 8'h20;
      chk(ien_reg == model, "R2", "fault enable setup", ien_reg, model);
      for (int m = 0; m < 4; m++) begin
        op_mode = 2'(m);
        foreach (rd[k]) begin end
        for (int t = 0; t < 7; t++) begin
          int n;
          int ei, er;
          n = (t == 0) ? 0 : (t == 1) ? 1 : (t == 2) ? 8 : (t == 3) ? 15 :
              (t == 4) ? 17 : (t == 5) ? 18 : 24;
          w0 = we_cnt; i0 = irq_cnt; r0 = rst_cnt;
          frame({2'b01, 2'b00, 8'hC3, 4'h0}, n, 1'b0, rd);
          ei = (en != 0 && (m == 0 || m == 3)) ? 1 : 0;
          er = (en != 0 && (m == 1 || m == 2)) ? 1 : 0;
          chk(ien_reg == model && we_cnt == w0, "R6", "no write on bad length",
              ien_reg, model);
          chk(irq_cnt - i0 == ei, "R7", "interrupt pulses", irq_cnt - i0, ei);
          chk(rst_cnt - r0 == er, "R8", "reset pulses", rst_cnt - r0, er);
        end
      end
      op_mode = 2'b00;
    end

    // R10 last edge coincides with release
    w0 = we_cnt;
    frame({2'b01, 2'b00, 8'h6C, 4'h0}, 16, 1'b1, rd);
    model = 8'h6C;
    chk(ien_reg == model && we_cnt == w0 + 1, "R10", "merged 16th edge commits",
        ien_reg, model);
    w0 = we_cnt;
    frame({2'b01, 2'b00, 8'h93, 4'h0}, 17, 1'b1, rd);
    chk(ien_reg == model && we_cnt == w0, "R10", "merged 17th edge rejects",
        ien_reg, model);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule